// File: doc/BRIEF.md
# Multi-Level Page Table Walker

This block turns a virtual address into a physical address by reading page table entries from memory, one level at a time. A request carries the virtual address, the kind of access (load, store or instruction fetch) and whether the access comes from user mode. The walk starts at a table base register value that is sampled when the request is accepted. The virtual page number is cut into equal index fields, one for each level. Each level reads one entry. A non-final entry names the page that holds the next table, and the final entry gives the physical page number and the permission flags.

Requests, entry reads, read data and results all move over valid/ready channels. A transfer happens on a rising edge where both valid and ready are high. A sender that has raised valid keeps it high, and keeps its payload unchanged, until the transfer happens. The walker accepts a new request only while it is idle. It has at most one entry read open at a time. It holds its result until the consumer takes it. The result is either a physical address, a page fault (an entry is missing or malformed) or a protection fault (the final entry forbids the access). The two fault kinds come out on separate pins.

Top module: `ptw_walker`

## Requirements
- R1: `req_ready` is high only in the idle state. A request is taken on an edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low until the edge that transfers the result, and it is high again on the cycle after that edge.
- R2: Level 1 reads from the table base sampled at acceptance plus 4 times VA[31:22]. Level 2 reads from the page named by the level-1 entry (PPN shifted left by 12) plus 4 times VA[21:12]. A change of `root_base` after acceptance does not affect a walk in progress.
- R3: Entry layout: bit 0 valid, bit 1 readable, bit 2 writable, bit 3 executable, bit 4 supervisor-only, bits 11:5 reserved, bits 31:12 physical page number.
- R4: At most one entry read is open at a time. `mem_rd_valid` stays high with `mem_rd_addr` unchanged until `mem_rd_ready` is seen.
- R5: An entry at any level whose valid bit is 0 ends the walk at once. The result has page fault set, protection fault clear and address zero, and no further read is made.
- R6: A walk that passes all checks returns the final entry's page number joined with VA[11:0], with both fault flags clear.
- R7: Access kind encoding: 0 load, 1 store, 2 fetch, 3 treated as load. On the final entry, a load without the readable bit, a store without the writable bit, a fetch without the executable bit, or a user access (`req_user`=1) to a supervisor-only page gives a protection fault with address zero.
- R8: A supervisor access (`req_user`=0) may use a page whose supervisor-only bit is set, subject to the other permission bits.
- R9: While `rsp_valid` is high and `rsp_ready` is low, the result address and both fault flags stay unchanged.
- R10: The readable, writable, executable and supervisor-only bits of a non-final entry are ignored. Only its valid bit, its reserved bits and its page number matter.
- R11: An entry with any reserved bit (11:5) set counts as not valid and gives a page fault, at any level.
- R12: After reset, `req_ready` is high and `mem_rd_valid` and `rsp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_base | input | 32 | Physical address of the first-level table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_kind | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 load |
| req_user | input | 1 | 1 = user-mode access |
| mem_rd_valid | output | 1 | Entry read request present |
| mem_rd_ready | input | 1 | Memory takes the read request |
| mem_rd_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Entry data present |
| mem_rsp_ready | output | 1 | Walker takes entry data |
| mem_rsp_data | input | 32 | Entry word |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_paddr | output | 32 | Physical address, zero on a fault |
| rsp_page_fault | output | 1 | Missing or malformed entry |
| rsp_prot_fault | output | 1 | Final entry forbids the access |

## Verification
Most state errors reach a pin within one walk. A wrong level counter or a wrong stored table base shows up at the next read handshake as a wrong `mem_rd_addr`, or as the wrong number of reads. A wrong stored access kind or privilege shows up in the fault flags of that same result. A state machine that stalls keeps `req_ready` low or `rsp_valid` stuck high, so the next request cannot be issued. The bench compares every read address, the read count and the result of each walk against its own model of the table.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD     = 2'd0,
    ACC_STORE    = 2'd1,
    ACC_FETCH    = 2'd2,
    ACC_LOAD_ALT = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    WS_IDLE,
    WS_ISSUE,
    WS_WAIT,
    WS_RESP
  } walk_state_e;

  // Entry flag positions (low bits of every table entry)
  localparam int PTE_V_BIT   = 0;
  localparam int PTE_R_BIT   = 1;
  localparam int PTE_W_BIT   = 2;
  localparam int PTE_X_BIT   = 3;
  localparam int PTE_SUP_BIT = 4;
  localparam int PTE_RSV_LO  = 5;

  typedef struct packed {
    logic sup;
    logic x;
    logic w;
    logic r;
  } pte_perm_t;

endpackage

// File: rtl/ptw_vpn_slicer.sv
module ptw_vpn_slicer #(
  parameter int VPN_W  = 20,
  parameter int LEVELS = 2,
  parameter int IDX_W  = 10,
  parameter int LVL_W  = 1
) (
  input  logic [VPN_W-1:0] vpn,
  input  logic [LVL_W-1:0] level,
  output logic [IDX_W-1:0] idx
);

  logic [IDX_W-1:0] fields [LEVELS];

  // Level 0 uses the most significant field of the page number
  for (genvar g = 0; g < LEVELS; g++) begin : g_field
    assign fields[g] = vpn[VPN_W-1-g*IDX_W -: IDX_W];
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < LEVELS; i++) begin
      if (level == LVL_W'(i)) idx = fields[i];
    end
  end

endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int PA_W        = 32,
  parameter int IDX_W       = 10,
  parameter int ENTRY_SHIFT = 2
) (
  input  logic [PA_W-1:0]  table_base,
  input  logic [IDX_W-1:0] idx,
  output logic [PA_W-1:0]  entry_addr
);

  logic [PA_W-1:0] byte_off;

  assign byte_off   = PA_W'(idx) << ENTRY_SHIFT;
  assign entry_addr = table_base + byte_off;

endmodule

// File: rtl/ptw_entry_decode.sv
module ptw_entry_decode
  import ptw_pkg::*;
#(
  parameter int PTE_W     = 32,
  parameter int PAGE_BITS = 12,
  parameter int PPN_W     = 20
) (
  input  logic [PTE_W-1:0] raw,
  output logic             present,
  output pte_perm_t        perm,
  output logic [PPN_W-1:0] ppn
);

  logic rsv_clean;

  assign rsv_clean = (raw[PAGE_BITS-1:PTE_RSV_LO] == '0);
  assign present   = raw[PTE_V_BIT] && rsv_clean;
  assign perm.r    = raw[PTE_R_BIT];
  assign perm.w    = raw[PTE_W_BIT];
  assign perm.x    = raw[PTE_X_BIT];
  assign perm.sup  = raw[PTE_SUP_BIT];
  assign ppn       = raw[PTE_W-1 -: PPN_W];

endmodule

// File: rtl/ptw_perm_check.sv
module ptw_perm_check
  import ptw_pkg::*;
(
  input  pte_perm_t perm,
  input  acc_kind_e kind,
  input  logic      user,
  output logic      deny
);

  logic granted;

  always_comb begin
    unique case (kind)
      ACC_STORE: granted = perm.w;
      ACC_FETCH: granted = perm.x;
      default:   granted = perm.r;
    endcase
    deny = !granted || (user && perm.sup);
  end

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int LEVELS    = 2,
  parameter int PTE_W     = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PA_W-1:0] root_base,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic [1:0]      req_kind,
  input  logic            req_user,
  output logic            mem_rd_valid,
  input  logic            mem_rd_ready,
  output logic [PA_W-1:0] mem_rd_addr,
  input  logic            mem_rsp_valid,
  output logic            mem_rsp_ready,
  input  logic [PTE_W-1:0] mem_rsp_data,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [PA_W-1:0] rsp_paddr,
  output logic            rsp_page_fault,
  output logic            rsp_prot_fault
);

  localparam int VPN_W       = VA_W - PAGE_BITS;
  localparam int IDX_W       = VPN_W / LEVELS;
  localparam int PPN_W       = PA_W - PAGE_BITS;
  localparam int LVL_W       = (LEVELS > 1) ? $clog2(LEVELS) : 1;
  localparam int ENTRY_SHIFT = $clog2(PTE_W / 8);
  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

  walk_state_e      state_q;
  logic [LVL_W-1:0] level_q;
  logic [PA_W-1:0]  base_q;
  logic [VA_W-1:0]  vaddr_q;
  acc_kind_e        kind_q;
  logic             user_q;
  logic [PA_W-1:0]  paddr_q;
  logic             pf_q;
  logic             prot_q;

  logic [IDX_W-1:0] cur_idx;
  logic             ent_present;
  pte_perm_t        ent_perm;
  logic [PPN_W-1:0] ent_ppn;
  logic             ent_deny;
  logic             rsp_take;

  ptw_vpn_slicer #(
    .VPN_W (VPN_W),
    .LEVELS(LEVELS),
    .IDX_W (IDX_W),
    .LVL_W (LVL_W)
  ) u_slicer (
    .vpn  (vaddr_q[VA_W-1:PAGE_BITS]),
    .level(level_q),
    .idx  (cur_idx)
  );

  ptw_addr_gen #(
    .PA_W       (PA_W),
    .IDX_W      (IDX_W),
    .ENTRY_SHIFT(ENTRY_SHIFT)
  ) u_addr (
    .table_base(base_q),
    .idx       (cur_idx),
    .entry_addr(mem_rd_addr)
  );

  ptw_entry_decode #(
    .PTE_W    (PTE_W),
    .PAGE_BITS(PAGE_BITS),
    .PPN_W    (PPN_W)
  ) u_decode (
    .raw    (mem_rsp_data),
    .present(ent_present),
    .perm   (ent_perm),
    .ppn    (ent_ppn)
  );

  ptw_perm_check u_perm (
    .perm(ent_perm),
    .kind(kind_q),
    .user(user_q),
    .deny(ent_deny)
  );

  assign rsp_take = mem_rsp_valid && (state_q == WS_WAIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= WS_IDLE;
      level_q <= '0;
      base_q  <= '0;
      vaddr_q <= '0;
      kind_q  <= ACC_LOAD;
      user_q  <= 1'b0;
      paddr_q <= '0;
      pf_q    <= 1'b0;
      prot_q  <= 1'b0;
    end else begin
      unique case (state_q)
        WS_IDLE: begin
          if (req_valid) begin
            vaddr_q <= req_vaddr;
            kind_q  <= acc_kind_e'(req_kind);
            user_q  <= req_user;
            base_q  <= root_base;
            level_q <= '0;
            paddr_q <= '0;
            pf_q    <= 1'b0;
            prot_q  <= 1'b0;
            state_q <= WS_ISSUE;
          end
        end
        WS_ISSUE: begin
          if (mem_rd_ready) state_q <= WS_WAIT;
        end
        WS_WAIT: begin
          if (rsp_take) begin
            if (!ent_present) begin
              pf_q    <= 1'b1;
              state_q <= WS_RESP;
            end else if (level_q == LAST_LVL) begin
              if (ent_deny) prot_q  <= 1'b1;
              else          paddr_q <= {ent_ppn, vaddr_q[PAGE_BITS-1:0]};
              state_q <= WS_RESP;
            end else begin
              base_q  <= {ent_ppn, {PAGE_BITS{1'b0}}};
              level_q <= level_q + LVL_W'(1);
              state_q <= WS_ISSUE;
            end
          end
        end
        WS_RESP: begin
          if (rsp_ready) state_q <= WS_IDLE;
        end
        default: state_q <= WS_IDLE;
      endcase
    end
  end

  assign req_ready      = (state_q == WS_IDLE);
  assign mem_rd_valid   = (state_q == WS_ISSUE);
  assign mem_rsp_ready  = (state_q == WS_WAIT);
  assign rsp_valid      = (state_q == WS_RESP);
  assign rsp_paddr      = paddr_q;
  assign rsp_page_fault = pf_q;
  assign rsp_prot_fault = prot_q;

endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic [PAGE_BITS-1:0] req_off,
  input logic                 mem_rd_valid,
  input logic                 mem_rd_ready,
  input logic [PA_W-1:0]      mem_rd_addr,
  input logic                 mem_rsp_valid,
  input logic                 mem_rsp_ready,
  input logic                 rsp_valid,
  input logic                 rsp_ready,
  input logic [PA_W-1:0]      rsp_paddr,
  input logic                 rsp_page_fault,
  input logic                 rsp_prot_fault
);

  logic [1:0]           open_rd;
  logic [PAGE_BITS-1:0] off_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_rd <= '0;
      off_q   <= '0;
    end else begin
      open_rd <= open_rd + {1'b0, (mem_rd_valid && mem_rd_ready)}
                         - {1'b0, (mem_rsp_valid && mem_rsp_ready)};
      if (req_valid && req_ready) off_q <= req_off;
    end
  end

  // R1
  busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R1
  idle_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready) |=> req_ready);

  // R4
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

  // R4
  single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> (open_rd == 2'd0));

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr)
      && $stable(rsp_page_fault) && $stable(rsp_prot_fault)));

  // R5
  fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_page_fault && rsp_prot_fault));

  // R7
  fault_zero_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_page_fault || rsp_prot_fault)) |-> (rsp_paddr == '0));

  // R6
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_page_fault && !rsp_prot_fault)
      |-> (rsp_paddr[PAGE_BITS-1:0] == off_q));

endmodule

bind ptw_walker ptw_walker_chk #(
  .PA_W     (PA_W),
  .PAGE_BITS(PAGE_BITS)
) u_walker_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_off       (req_vaddr[PAGE_BITS-1:0]),
  .mem_rd_valid  (mem_rd_valid),
  .mem_rd_ready  (mem_rd_ready),
  .mem_rd_addr   (mem_rd_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .mem_rsp_ready (mem_rsp_ready),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_paddr     (rsp_paddr),
  .rsp_page_fault(rsp_page_fault),
  .rsp_prot_fault(rsp_prot_fault)
);

// File: tb/test_ptw_walker.sv
module test_ptw_walker;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] root_base;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_vaddr;
  logic [1:0]  req_kind;
  logic        req_user;
  logic        mem_rd_valid;
  logic        mem_rd_ready;
  logic [31:0] mem_rd_addr;
  logic        mem_rsp_valid;
  logic        mem_rsp_ready;
  logic [31:0] mem_rsp_data;
  logic        rsp_valid;
  logic        rsp_ready;
  logic [31:0] rsp_paddr;
  logic        rsp_page_fault;
  logic        rsp_prot_fault;

  int checks = 0;
  int errors = 0;
  logic [31:0] pmem [logic [31:0]];
  int rd_count;
  logic [3:0][31:0] rd_addr;

  localparam logic [31:0] ROOT  = 32'h0010_0000;
  localparam logic [31:0] TAB_A = 32'h0020_0000;
  localparam logic [31:0] TAB_B = 32'h0030_0000;

  always #5 clk = ~clk;

  ptw_walker i_ptw_walker (
    .clk(clk), .rst_n(rst_n), .root_base(root_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_kind(req_kind), .req_user(req_user),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_page_fault(rsp_page_fault), .rsp_prot_fault(rsp_prot_fault)
  );

  task automatic check_eq(input logic [31:0] act, input logic [31:0] exp,
                          input string req, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s (%s): actual=%h expected=%h", req, tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_pte(input logic [19:0] ppn, input logic sup,
      input logic x, input logic w, input logic r, input logic v);
    return {ppn, 7'b0, sup, x, w, r, v};
  endfunction

  function automatic logic [31:0] mk_va(input int l1, input int l2, input int off);
    return {l1[9:0], l2[9:0], off[11:0]};
  endfunction

  function automatic logic [31:0] rd_mem(input logic [31:0] a);
    if (pmem.exists(a)) return pmem[a];
    return 32'h0;
  endfunction

  // Reference walk built from R2, R3, R5, R6, R7, R10, R11
  function automatic void ref_walk(input logic [31:0] va, input logic [1:0] kind,
      input logic user, input logic [31:0] root, output logic pf, output logic prot,
      output logic [31:0] pa, output int n, output logic [3:0][31:0] addrs);
    logic [31:0] base, a, e;
    logic [9:0]  idx;
    logic        deny;
    base = root; pf = 1'b0; prot = 1'b0; pa = 32'h0; n = 0; addrs = '0;
    for (int lv = 0; lv < 2; lv++) begin
      idx = (lv == 0) ? va[31:22] : va[21:12];
      a = base + {20'h0, idx, 2'b00};
      addrs[lv] = a;
      n++;
      e = rd_mem(a);
      if (!e[0] || e[11:5] != 7'h0) begin
        pf = 1'b1;
        return;
      end
      if (lv == 1) begin
        deny = (user && e[4]) || (kind == 2'd1 && !e[2]) || (kind == 2'd2 && !e[3])
            || ((kind == 2'd0 || kind == 2'd3) && !e[1]);
        if (deny) prot = 1'b1;
        else      pa = {e[31:12], va[11:0]};
      end else begin
        base = {e[31:12], 12'h000};
      end
    end
  endfunction

  // Memory model: random read back-pressure and response delay
  initial begin
    logic [31:0] a;
    mem_rd_ready  = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = 32'h0;
    forever begin
      @(negedge clk);
      if (rst_n && mem_rd_valid) begin
        mem_rd_ready = ($urandom_range(0, 2) != 0);
        if (mem_rd_ready) begin
          a = mem_rd_addr;
          @(negedge clk);
          mem_rd_ready = 1'b0;
          if (rd_count < 4) rd_addr[rd_count] = a;
          rd_count++;
          repeat ($urandom_range(0, 3)) @(negedge clk);
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = rd_mem(a);
          @(negedge clk);
          mem_rsp_valid = 1'b0;
        end
      end
    end
  end

  task automatic run_req(input logic [31:0] va, input logic [1:0] kind,
                         input logic user, input bit swap_root, input string tag);
    logic epf, eprot, seen, c_pf, c_pr;
    logic [31:0] epa, saved_root, c_pa;
    int en;
    logic [3:0][31:0] ea;
    ref_walk(va, kind, user, root_base, epf, eprot, epa, en, ea);
    saved_root = root_base;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    rd_count  = 0;
    req_valid = 1'b1; req_vaddr = va; req_kind = kind; req_user = user;
    @(negedge clk);
    req_valid = 1'b0;
    check_eq({31'h0, req_ready}, 32'h0, "R1 busy after accept", tag);
    if (swap_root) root_base = saved_root ^ 32'h0F00_0000;
    seen = 1'b0; c_pa = '0; c_pf = 1'b0; c_pr = 1'b0;
    forever begin
      if (rsp_valid) begin
        if (!seen) begin
          seen = 1'b1; c_pa = rsp_paddr; c_pf = rsp_page_fault; c_pr = rsp_prot_fault;
        end
        if ($urandom_range(0, 2) == 0) break;
      end
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    check_eq({31'h0, rsp_page_fault}, {31'h0, epf}, "R5 R11 page fault", tag);
    check_eq({31'h0, rsp_prot_fault}, {31'h0, eprot}, "R7 R8 prot fault", tag);
    check_eq(rsp_paddr, epa, "R6 R3 paddr", tag);
    check_eq(32'(rd_count), 32'(en), "R4 R5 read count", tag);
    for (int i = 0; i < en && i < 4; i++)
      check_eq(rd_addr[i], ea[i], "R2 R10 entry address", tag);
    check_eq({c_pa[31:2], c_pf, c_pr}, {rsp_paddr[31:2], rsp_page_fault, rsp_prot_fault},
             "R9 result held while stalled", tag);
    @(negedge clk);
    rsp_ready = 1'b0;
    root_base = saved_root;
    check_eq({31'h0, req_ready}, 32'h1, "R1 idle after result", tag);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    report();
  end

  initial begin
    void'($urandom(32'd20240517));
    rst_n = 1'b0; root_base = ROOT; req_valid = 1'b0; req_vaddr = '0;
    req_kind = '0; req_user = 1'b0; rsp_ready = 1'b0; rd_count = 0; rd_addr = '0;

    // Level-1 entries: idx1 -> TAB_A with no permission bits (R10), idx3 -> TAB_B
    pmem[ROOT + 32'd4]  = mk_pte(TAB_A[31:12], 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    pmem[ROOT + 32'd12] = mk_pte(TAB_B[31:12], 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    pmem[ROOT + 32'd16] = mk_pte(TAB_A[31:12], 1'b0, 1'b0, 1'b0, 1'b1, 1'b1) | 32'h40;
    // Leaves in TAB_A
    pmem[TAB_A + 32'd0]  = mk_pte(20'hABCDE, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    pmem[TAB_A + 32'd4]  = mk_pte(20'h11111, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    pmem[TAB_A + 32'd8]  = mk_pte(20'h22222, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    pmem[TAB_A + 32'd12] = mk_pte(20'h33333, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    pmem[TAB_A + 32'd16] = mk_pte(20'h44444, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    pmem[TAB_A + 32'd20] = mk_pte(20'h55555, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1) | 32'h100;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq({31'h0, req_ready}, 32'h1, "R12 reset req_ready", "reset");
    check_eq({31'h0, mem_rd_valid}, 32'h0, "R12 reset mem_rd_valid", "reset");
    check_eq({31'h0, rsp_valid}, 32'h0, "R12 reset rsp_valid", "reset");

    run_req(mk_va(1, 0, 12'hFFF), 2'd0, 1'b1, 1'b0, "load ok R10");
    run_req(mk_va(1, 0, 12'h000), 2'd1, 1'b1, 1'b0, "store ok");
    run_req(mk_va(1, 1, 12'h123), 2'd1, 1'b1, 1'b0, "store read-only R7");
    run_req(mk_va(1, 1, 12'h123), 2'd2, 1'b0, 1'b0, "fetch no-exec R7");
    run_req(mk_va(1, 2, 12'h456), 2'd2, 1'b1, 1'b0, "fetch ok");
    run_req(mk_va(1, 2, 12'h456), 2'd0, 1'b0, 1'b0, "load unreadable R7");
    run_req(mk_va(1, 2, 12'h456), 2'd3, 1'b0, 1'b0, "kind3 as load R7");
    run_req(mk_va(1, 0, 12'h789), 2'd3, 1'b1, 1'b0, "kind3 ok");
    run_req(mk_va(1, 3, 12'h010), 2'd0, 1'b1, 1'b0, "user to sup R7");
    run_req(mk_va(1, 3, 12'h010), 2'd1, 1'b0, 1'b0, "sup to sup R8");
    run_req(mk_va(2, 0, 12'h000), 2'd0, 1'b0, 1'b0, "level1 invalid R5");
    run_req(mk_va(1, 4, 12'h000), 2'd0, 1'b0, 1'b0, "level2 invalid R5");
    run_req(mk_va(1, 5, 12'h000), 2'd0, 1'b0, 1'b0, "leaf reserved R11");
    run_req(mk_va(4, 0, 12'h000), 2'd0, 1'b0, 1'b0, "nonleaf reserved R11");
    run_req(mk_va(1, 0, 12'hABC), 2'd0, 1'b0, 1'b1, "root change mid-walk R2");

    for (int it = 0; it < 300; it++) begin
      int l1, l2, sel;
      logic [31:0] leaf;
      l2 = int'($urandom_range(0, 7));
      leaf = mk_pte(20'($urandom()), 1'($urandom()), 1'($urandom()), 1'($urandom()),
                    1'($urandom()), ($urandom_range(0, 7) != 0));
      if ($urandom_range(0, 15) == 0) leaf = leaf | 32'h20;
      pmem[TAB_B + 32'(l2 * 4)] = leaf;
      sel = int'($urandom_range(0, 3));
      l1 = (sel == 0) ? 1 : (sel == 1) ? 3 : (sel == 2) ? 2 : int'($urandom_range(0, 1023));
      run_req(mk_va(l1, l2, int'($urandom_range(0, 4095))), 2'($urandom()),
              1'($urandom()), ($urandom_range(0, 7) == 0), "random");
    end

    report();
  end

endmodule